// File: doc/BRIEF.md
# Two-Way Page-Indexed Data Cache with Physical Tags

This block is a read data cache that sits beside an address translation unit. The set index and the word-select bits are taken only from the untranslated low bits of the virtual address, that is, from the page offset. The tag and data arrays can therefore be read in the same cycle that the request is accepted, while translation runs in parallel. One cycle later the translation unit presents the physical page number. The block compares it against the physical page numbers stored in both ways of the selected set and answers in that same cycle.

With a 4 KB page, the 12 page-offset bits are split into 8 set bits and 4 line-offset bits. That gives 256 sets of 16-byte lines in each way. Capacity beyond one page comes from associativity: two ways give 8 KB, and one recency bit per set picks the victim. On a miss the block stalls the requester. It asks memory for the line over a simple fill port, accepts four 32-bit words in ascending order, installs the line and then returns the requested word. A translation fault reported in the compare stage ends the access at once. A faulting access allocates nothing and starts no fill.

Top module: `vipt_dcache`

## Requirements
- R1: The set is `req_vaddr[11:4]` and the word within the line is `req_vaddr[3:2]`. Virtual address bits 31:12 have no effect on the lookup.
- R2: In the cycle after a request is accepted, the block compares `xlat_ppn` with the physical page number held in each valid way of the set. On a match it raises `resp_valid` and `resp_hit` in that same cycle, with the stored word on `resp_data`. `resp_hit` and `resp_fault` are never high together.
- R3: On a miss, `req_ready` drops in the compare cycle. From the next cycle `fill_req` is high and `req_ready` is low. `fill_addr` holds `{xlat_ppn, set, 4'b0000}` and stays steady until the fill ends.
- R4: Fill beat k (k = 0..3) carries the word at byte offset 4*k of the line. The cycle after the fourth beat, the block gives `resp_valid=1`, `resp_hit=0`, `resp_fault=0` and the requested word. `req_ready` returns the cycle after that.
- R5: When `xlat_fault` is high in the compare cycle, the block gives `resp_valid=1`, `resp_fault=1` and `resp_hit=0`. It raises no `fill_req`, keeps `req_ready` high and changes no resident line.
- R6: The two ways of one set can hold lines of two different physical pages at the same time, and both of them hit.
- R7: Replacement fills an invalid way first, way 0 before way 1. When both ways are valid it evicts the less recently used way, and both hits and installs count as uses.
- R8: After reset `req_ready=1`, `resp_valid=0` and `fill_req=0`, and every line is invalid, so the first access misses.
- R9: While requests keep hitting, a new request is accepted every cycle and one response comes out per cycle, in request order.
- R10: Fill beats may arrive with idle cycles between them. While `fill_valid` is low nothing advances and no response is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual byte address of the request |
| req_ready | output | 1 | Request accepted on this edge when high |
| xlat_ppn | input | 20 | Physical page number, valid in the cycle after acceptance |
| xlat_fault | input | 1 | Translation fault for the access in the compare stage |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Response came from a hit |
| resp_fault | output | 1 | Response reports a translation fault |
| resp_data | output | 32 | Requested word |
| fill_req | output | 1 | Line fill in progress |
| fill_addr | output | 32 | Physical address of the line being filled |
| fill_valid | input | 1 | A fill word is present |
| fill_data | input | 32 | Fill word, ascending order within the line |

## Verification
A corrupted stored page number, or a valid bit set in error, shows up in the compare cycle itself: a repeat access to a line that was just installed misses and `fill_req` rises one cycle later, or an access that should miss answers with a hit. A wrong recency bit stays hidden until the third distinct page is mapped into a set. The wrong way is then evicted, and the next access to the line that should have stayed resident misses. A fill counter that is off by one returns a word from the wrong offset in the reply cycle, and that word differs from the computed memory pattern.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

  // Associativity is fixed at two so that one bit per set tracks recency.
  localparam int NUM_WAYS = 2;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FILL  = 2'd1,
    ST_REPLY = 2'd2
  } ctl_state_e;

  // Invalid ways are used first (way 0 before way 1), else the recency bit.
  function automatic logic pick_victim(input logic [NUM_WAYS-1:0] vld,
                                       input logic               older);
    if (!vld[0])      return 1'b0;
    else if (!vld[1]) return 1'b1;
    else              return older;
  endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store
  import vipt_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int TAG_W = 20
)(
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic [SET_W-1:0]                  rd_set,
  output logic [NUM_WAYS-1:0][TAG_W-1:0]    rd_tag,
  output logic [NUM_WAYS-1:0]               rd_vld,
  input  logic [SET_W-1:0]                  age_set,
  output logic                              age_bit,
  input  logic                              age_we,
  input  logic [SET_W-1:0]                  age_wset,
  input  logic                              age_wval,
  input  logic                              wr_en,
  input  logic [SET_W-1:0]                  wr_set,
  input  logic                              wr_way,
  input  logic [TAG_W-1:0]                  wr_tag
);
  localparam int SETS = 1 << SET_W;

  logic [SETS-1:0] age_q;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_mem;
    logic [TAG_W-1:0] tag_rd_q;
    logic             vld_rd_q;
    logic             wr_here;

    assign wr_here = wr_en && (wr_way == 1'(w));

    always_ff @(posedge clk) begin
      if (wr_here) tag_mem[wr_set] <= wr_tag;
      if (rd_en)   tag_rd_q <= tag_mem[rd_set];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_mem  <= '0;
        vld_rd_q <= 1'b0;
      end else begin
        if (wr_here) vld_mem[wr_set] <= 1'b1;
        if (rd_en)   vld_rd_q <= vld_mem[rd_set];
      end
    end

    assign rd_tag[w] = tag_rd_q;
    assign rd_vld[w] = vld_rd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      age_q <= '0;
    else if (age_we) age_q[age_wset] <= age_wval;
  end

  assign age_bit = age_q[age_set];

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store
  import vipt_pkg::*;
#(
  parameter int SET_W  = 8,
  parameter int LINE_W = 128
)(
  input  logic                              clk,
  input  logic                              rd_en,
  input  logic [SET_W-1:0]                  rd_set,
  output logic [NUM_WAYS-1:0][LINE_W-1:0]   rd_line,
  input  logic                              wr_en,
  input  logic [SET_W-1:0]                  wr_set,
  input  logic                              wr_way,
  input  logic [LINE_W-1:0]                 wr_line
);
  localparam int SETS = 1 << SET_W;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic [LINE_W-1:0] line_mem [SETS];
    logic [LINE_W-1:0] line_rd_q;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_way == 1'(w))) line_mem[wr_set] <= wr_line;
      if (rd_en) line_rd_q <= line_mem[rd_set];
    end

    assign rd_line[w] = line_rd_q;
  end

endmodule

// File: rtl/vipt_fill_ctrl.sv
module vipt_fill_ctrl #(
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
)(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         active,
  input  logic                         beat_valid,
  input  logic [WORD_W-1:0]            beat_data,
  output logic [WORD_W*LINE_WORDS-1:0] line,
  output logic                         last_beat
);
  localparam int CNT_W  = $clog2(LINE_WORDS);
  localparam int LINE_W = WORD_W * LINE_WORDS;

  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] buf_q;
  logic              take;

  assign take      = active && beat_valid;
  assign last_beat = take && (cnt_q == CNT_W'(LINE_WORDS - 1));

  // The assembled line already holds the beat arriving this cycle.
  always_comb begin
    line = buf_q;
    for (int k = 0; k < LINE_WORDS; k++) begin
      if (take && (cnt_q == CNT_W'(k))) line[k*WORD_W +: WORD_W] = beat_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      buf_q <= '0;
    end else if (take) begin
      buf_q <= line;
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/vipt_dcache.sv
module vipt_dcache
  import vipt_pkg::*;
#(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
)(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [VA_W-1:0]        req_vaddr,
  output logic                   req_ready,
  input  logic [PA_W-PAGE_W-1:0] xlat_ppn,
  input  logic                   xlat_fault,
  output logic                   resp_valid,
  output logic                   resp_hit,
  output logic                   resp_fault,
  output logic [WORD_W-1:0]      resp_data,
  output logic                   fill_req,
  output logic [PA_W-1:0]        fill_addr,
  input  logic                   fill_valid,
  input  logic [WORD_W-1:0]      fill_data
);
  localparam int PPN_W  = PA_W - PAGE_W;
  localparam int LINE_W = WORD_W * LINE_WORDS;
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int BYTE_W = $clog2(WORD_W / 8);
  localparam int OFF_W  = WSEL_W + BYTE_W;
  // The set index takes every page-offset bit above the line offset, so
  // no index bit ever comes from the translated part of the address.
  localparam int SET_W  = PAGE_W - OFF_W;

  function automatic logic [SET_W-1:0] set_of(input logic [VA_W-1:0] va);
    return va[OFF_W +: SET_W];
  endfunction

  function automatic logic [WSEL_W-1:0] wsel_of(input logic [VA_W-1:0] va);
    return va[BYTE_W +: WSEL_W];
  endfunction

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] ln,
                                                input logic [WSEL_W-1:0] s);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int k = 0; k < LINE_WORDS; k++) begin
      if (s == WSEL_W'(k)) w = ln[k*WORD_W +: WORD_W];
    end
    return w;
  endfunction

  function automatic logic [PA_W-1:0] line_pa(input logic [PPN_W-1:0] p,
                                              input logic [SET_W-1:0] s);
    return {p, s, {OFF_W{1'b0}}};
  endfunction

  // Stage one
  logic               accept;
  logic               s2_valid_q;
  logic [SET_W-1:0]   s2_set_q;
  logic [WSEL_W-1:0]  s2_wsel_q;

  // Arrays
  logic [NUM_WAYS-1:0][PPN_W-1:0]  rd_tag;
  logic [NUM_WAYS-1:0]             rd_vld;
  logic [NUM_WAYS-1:0][LINE_W-1:0] rd_line;
  logic                            age_bit;
  logic                            age_we;
  logic [SET_W-1:0]                age_wset;
  logic                            age_wval;

  // Stage two and miss handling
  ctl_state_e          st_q;
  logic [NUM_WAYS-1:0] way_hit;
  logic                hit_way;
  logic                victim;
  logic [LINE_W-1:0]   hit_line;
  logic [PPN_W-1:0]    miss_ppn_q;
  logic [SET_W-1:0]    miss_set_q;
  logic [WSEL_W-1:0]   miss_wsel_q;
  logic                miss_way_q;
  logic [WORD_W-1:0]   reply_q;
  logic [LINE_W-1:0]   fill_line;
  logic                last_beat;

  // Named events for the checker
  logic ev_hit;
  logic ev_miss;
  logic ev_fault;
  logic ev_install;

  logic unused_hi_va;
  assign unused_hi_va = ^{req_vaddr[VA_W-1:PAGE_W], req_vaddr[BYTE_W-1:0]};

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid_q <= 1'b0;
      s2_set_q   <= '0;
      s2_wsel_q  <= '0;
    end else begin
      s2_valid_q <= accept;
      if (accept) begin
        s2_set_q  <= set_of(req_vaddr);
        s2_wsel_q <= wsel_of(req_vaddr);
      end
    end
  end

  vipt_tag_store #(.SET_W(SET_W), .TAG_W(PPN_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (accept),
    .rd_set   (set_of(req_vaddr)),
    .rd_tag   (rd_tag),
    .rd_vld   (rd_vld),
    .age_set  (s2_set_q),
    .age_bit  (age_bit),
    .age_we   (age_we),
    .age_wset (age_wset),
    .age_wval (age_wval),
    .wr_en    (ev_install),
    .wr_set   (miss_set_q),
    .wr_way   (miss_way_q),
    .wr_tag   (miss_ppn_q)
  );

  vipt_data_store #(.SET_W(SET_W), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_en   (accept),
    .rd_set  (set_of(req_vaddr)),
    .rd_line (rd_line),
    .wr_en   (ev_install),
    .wr_set  (miss_set_q),
    .wr_way  (miss_way_q),
    .wr_line (fill_line)
  );

  vipt_fill_ctrl #(.WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_fill (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (st_q == ST_FILL),
    .beat_valid (fill_valid),
    .beat_data  (fill_data),
    .line       (fill_line),
    .last_beat  (last_beat)
  );

  // Physical tag compare against the translated page number
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
    assign way_hit[w] = s2_valid_q && rd_vld[w] && (rd_tag[w] == xlat_ppn);
  end

  assign hit_way  = way_hit[1];
  assign hit_line = hit_way ? rd_line[1] : rd_line[0];
  assign victim   = pick_victim(rd_vld, age_bit);

  assign ev_fault   = (st_q == ST_RUN) && s2_valid_q && xlat_fault;
  assign ev_hit     = (st_q == ST_RUN) && !xlat_fault && (|way_hit);
  assign ev_miss    = (st_q == ST_RUN) && s2_valid_q && !xlat_fault && !(|way_hit);
  assign ev_install = (st_q == ST_FILL) && last_beat;

  // The recency bit names the way to evict next.
  assign age_we   = ev_hit || ev_install;
  assign age_wset = ev_install ? miss_set_q : s2_set_q;
  assign age_wval = ev_install ? ~miss_way_q : ~hit_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_RUN;
      miss_ppn_q  <= '0;
      miss_set_q  <= '0;
      miss_wsel_q <= '0;
      miss_way_q  <= 1'b0;
      reply_q     <= '0;
    end else begin
      case (st_q)
        ST_RUN: if (ev_miss) begin
          st_q        <= ST_FILL;
          miss_ppn_q  <= xlat_ppn;
          miss_set_q  <= s2_set_q;
          miss_wsel_q <= s2_wsel_q;
          miss_way_q  <= victim;
        end
        ST_FILL: if (ev_install) begin
          st_q    <= ST_REPLY;
          reply_q <= word_of(fill_line, miss_wsel_q);
        end
        ST_REPLY: st_q <= ST_RUN;
        default:  st_q <= ST_RUN;
      endcase
    end
  end

  assign req_ready  = (st_q == ST_RUN) && !ev_miss;
  assign resp_valid = ev_hit || ev_fault || (st_q == ST_REPLY);
  assign resp_hit   = ev_hit;
  assign resp_fault = ev_fault;
  assign resp_data  = (st_q == ST_REPLY) ? reply_q :
                      ev_hit ? word_of(hit_line, s2_wsel_q) : '0;
  assign fill_req   = (st_q == ST_FILL);
  assign fill_addr  = line_pa(miss_ppn_q, miss_set_q);

endmodule

// File: rtl/vipt_dcache_chk.sv
module vipt_dcache_chk #(
  parameter int PA_W = 32
)(
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            resp_valid,
  input logic            resp_hit,
  input logic            resp_fault,
  input logic            fill_req,
  input logic [PA_W-1:0] fill_addr,
  input logic            s2_valid_q,
  input logic [1:0]      way_hit,
  input logic            ev_miss,
  input logic            ev_fault,
  input logic            ev_install
);

  assert_exclusive_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> !(resp_hit && resp_fault));

  assert_stall_while_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |-> !req_ready);

  assert_miss_opens_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_miss |=> fill_req);

  assert_fill_addr_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req |=> (!fill_req || $stable(fill_addr)));

  assert_reply_after_install_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_install |=> (resp_valid && !resp_hit && !resp_fault));

  assert_fault_no_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fault |=> !fill_req);

  assert_one_way_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid_q |-> $onehot0(way_hit));

endmodule

bind vipt_dcache vipt_dcache_chk #(.PA_W(PA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .resp_valid (resp_valid),
  .resp_hit   (resp_hit),
  .resp_fault (resp_fault),
  .fill_req   (fill_req),
  .fill_addr  (fill_addr),
  .s2_valid_q (s2_valid_q),
  .way_hit    (way_hit),
  .ev_miss    (ev_miss),
  .ev_fault   (ev_fault),
  .ev_install (ev_install)
);

// File: tb/sim_vipt_dcache.sv
`timescale 1ns/1ps
module sim_vipt_dcache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic [19:0] xlat_ppn = '0;
  logic        xlat_fault = 1'b0;
  logic        resp_valid;
  logic        resp_hit;
  logic        resp_fault;
  logic [31:0] resp_data;
  logic        fill_req;
  logic [31:0] fill_addr;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vipt_dcache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
    .xlat_ppn(xlat_ppn), .xlat_fault(xlat_fault),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_fault(resp_fault),
    .resp_data(resp_data),
    .fill_req(fill_req), .fill_addr(fill_addr),
    .fill_valid(fill_valid), .fill_data(fill_data)
  );

  // Memory contents: a fixed scramble of the physical byte address.
  function automatic logic [31:0] mem_word(input logic [31:0] pa);
    return (pa * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] word_pa(input logic [19:0] ppn, input logic [31:0] va);
    return {ppn, va[11:2], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(req_ready == 1'b1, "R8 ready after reset", 32'(req_ready), 32'd1);
    chk(resp_valid == 1'b0, "R8 no response after reset", 32'(resp_valid), 32'd0);
    chk(fill_req == 1'b0, "R8 no fill after reset", 32'(fill_req), 32'd0);
  endtask

  // Expect a hit in the compare cycle (R2).
  task automatic t_hit(input logic [31:0] va, input logic [19:0] ppn, input string rq);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    #1;
    chk(req_ready == 1'b1, {rq, " ready"}, 32'(req_ready), 32'd1);
    @(negedge clk);
    req_valid = 1'b0; xlat_ppn = ppn; xlat_fault = 1'b0;
    #1;
    chk(resp_valid && resp_hit && !resp_fault, {rq, " R2 hit flags"},
        {29'd0, resp_valid, resp_hit, resp_fault}, 32'd6);
    chk(resp_data == mem_word(word_pa(ppn, va)), {rq, " R2 hit data"},
        resp_data, mem_word(word_pa(ppn, va)));
  endtask

  // Expect a miss, a fill (R3, R10) and the reply (R4).
  task automatic t_miss(input logic [31:0] va, input logic [19:0] ppn, input int gap,
                        input string rq);
    logic [31:0] lpa;
    lpa = {ppn, va[11:4], 4'h0};
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; xlat_ppn = ppn; xlat_fault = 1'b0;
    #1;
    chk(!resp_valid && !req_ready, {rq, " R3 miss stalls"},
        {30'd0, resp_valid, req_ready}, 32'd0);
    @(negedge clk);
    #1;
    chk(fill_req == 1'b1, {rq, " R3 fill request"}, 32'(fill_req), 32'd1);
    chk(fill_addr == lpa, {rq, " R3 fill address"}, fill_addr, lpa);
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < gap; g++) begin
        fill_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(fill_req && !resp_valid, {rq, " R10 idle beat ignored"},
            {30'd0, fill_req, resp_valid}, 32'd2);
      end
      fill_valid = 1'b1; fill_data = mem_word(lpa + 32'(4 * k));
      @(negedge clk);
    end
    fill_valid = 1'b0; fill_data = '0;
    #1;
    chk(resp_valid && !resp_hit && !resp_fault, {rq, " R4 reply flags"},
        {29'd0, resp_valid, resp_hit, resp_fault}, 32'd4);
    chk(resp_data == mem_word(word_pa(ppn, va)), {rq, " R4 reply data"},
        resp_data, mem_word(word_pa(ppn, va)));
    @(negedge clk);
    #1;
    chk(req_ready && !fill_req, {rq, " R4 ready returns"},
        {30'd0, req_ready, fill_req}, 32'd2);
  endtask

  task automatic t_fault(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0; xlat_fault = 1'b1;
    #1;
    chk(resp_valid && resp_fault && !resp_hit && req_ready, "R5 fault response",
        {28'd0, resp_valid, resp_fault, resp_hit, req_ready}, 32'hD);
    @(negedge clk);
    xlat_fault = 1'b0;
    #1;
    chk(!fill_req && !resp_valid, "R5 fault starts no fill",
        {30'd0, fill_req, resp_valid}, 32'd0);
  endtask

  // Two hits back to back, one response per cycle (R9).
  task automatic t_pipe(input logic [31:0] va1, input logic [19:0] p1,
                        input logic [31:0] va2, input logic [19:0] p2);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va1;
    @(negedge clk);
    req_vaddr = va2; xlat_ppn = p1; xlat_fault = 1'b0;
    #1;
    chk(resp_valid && resp_hit && req_ready, "R9 first of pair",
        {29'd0, resp_valid, resp_hit, req_ready}, 32'd7);
    chk(resp_data == mem_word(word_pa(p1, va1)), "R9 first data",
        resp_data, mem_word(word_pa(p1, va1)));
    @(negedge clk);
    req_valid = 1'b0; xlat_ppn = p2;
    #1;
    chk(resp_valid && resp_hit, "R9 second of pair",
        {30'd0, resp_valid, resp_hit}, 32'd3);
    chk(resp_data == mem_word(word_pa(p2, va2)), "R9 second data",
        resp_data, mem_word(word_pa(p2, va2)));
  endtask

  localparam logic [19:0] PG_A = 20'h11111;
  localparam logic [19:0] PG_B = 20'h22222;
  localparam logic [19:0] PG_C = 20'h33333;

  initial begin
    t_reset();
    t_miss(32'h0000_0104, PG_A, 0, "R8 first access misses");
    t_hit(32'hDEAD_010C, PG_A, "R1 upper virtual bits ignored");
    t_miss(32'h0000_0108, PG_B, 1, "R6 second page into set");
    t_hit(32'h0000_0100, PG_A, "R6 way A resident");
    t_hit(32'h0000_0104, PG_B, "R6 way B resident");
    t_pipe(32'h0000_0108, PG_B, 32'h0000_0100, PG_A);
    t_fault(32'h0000_0104);
    t_hit(32'h0000_0104, PG_A, "R5 line kept after fault");
    t_miss(32'h0000_010C, PG_C, 0, "R7 third page evicts older");
    t_hit(32'h0000_0100, PG_A, "R7 recent line kept");
    t_hit(32'h0000_0108, PG_C, "R7 new line resident");
    t_miss(32'h0000_0100, PG_B, 2, "R7 evicted line misses");
    t_miss(32'h0000_0FFC, PG_A, 0, "R1 last set");
    t_hit(32'h0000_0FF0, PG_A, "R1 last set word 0");
    t_miss(32'h0000_0FF8, 20'h44444, 0, "R2 other page same set misses");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule